// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Sync Generator

This block produces the timing for a synchronous serial voice or audio port. A bit clock is either made by dividing the peripheral clock, which advances only in cycles where a clock enable is high, or taken from an external clock pin after synchronisation. Each rising edge of the selected bit clock advances a word counter whose length is 8, 10, 12 or 16 bits. Each completed word advances a frame counter whose length runs from 1 to 32 words.

The block emits a registered bit clock and a one-cycle word tick at every word boundary. It also emits a frame sync that is high for one bit period over the first bit of word 0. Both the bit clock and the frame sync can be inverted. The frame sync can also come from an external pin, bypassing the internal counters.

Any change to the divider, word-length, frame-length or bit-source setting restarts all three counters in the same cycle. The first bit edge after the change then opens a clean frame.

Top module: `bit_frame_clkgen`

## Requirements
- R1: With the internal source selected and divide value N, the bit clock holds each level for exactly N+1 enabled peripheral cycles, so its period is 2(N+1) cycles while the enable stays high.
- R2: While the clock enable is low and the internal source is selected, the bit-clock output does not change.
- R3: Word-length code 0, 1, 2 and 3 selects 8, 10, 12 and 16 bits per word. The word tick pulses for one cycle, once per word, so a frame contains exactly (frame code + 1) ticks.
- R4: Frame-length code F (0 to 31) gives F+1 words per frame. Rising edges of the frame sync are spaced by one full frame of bit periods.
- R5: The internal frame sync is high for exactly one bit period per frame. It rises together with the word tick that starts word 0.
- R6: With the bit-clock invert input at 1, the bit-clock output is the complement of its non-inverted value.
- R7: With the frame-sync invert input at 1, the frame-sync output is the complement of its non-inverted value.
- R8: With the external bit source selected, bit, word and frame timing follow the rising edges of the external clock pin after synchronisation.
- R9: With the external frame-sync source selected, the output follows the external frame-sync pin, inverted if the invert input is 1, within four cycles.
- R10: A change to divide value, word length, frame length or bit source restarts the counters. With the internal source and divide value N, the frame sync then rises exactly N+3 cycles after the first clock edge that sees the change, and never earlier.
- R11: While reset is asserted and both invert inputs are 0, bit clock, word tick and frame sync are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Prescaler advance enable |
| divVal | input | DIV_W | Prescaler divide value N (half period N+1) |
| wordSel | input | 2 | Word-length code: 0=8, 1=10, 2=12, 3=16 bits |
| frameLen | input | FRAME_W | Words per frame minus one |
| bitSrcExt | input | 1 | 1 selects the external bit clock |
| fsSrcExt | input | 1 | 1 selects the external frame sync |
| bitClkInv | input | 1 | Invert the bit-clock output |
| fsInv | input | 1 | Invert the frame-sync output |
| extBitClk | input | 1 | External bit-clock pin |
| extFrameSync | input | 1 | External frame-sync pin |
| bitClkOut | output | 1 | Bit clock |
| wordTick | output | 1 | One-cycle pulse at each word start |
| frameSyncOut | output | 1 | Frame sync |

## Verification
The bench uses the default parameters: an 8-bit divide value and a 5-bit frame code. This brings the extremes of the word and frame ranges within reach, including 32 words of 16 bits at the fastest divide and single-word frames. A vector table sweeps all four word lengths, several divide values and frame lengths, plus an external clock with a half period of five cycles. Each frame is measured edge to edge. Directed cases then freeze the prescaler to test inversion, exercise the external frame-sync bypass, and time the first frame after a configuration change to the exact cycle.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  localparam int BIT_IDX_W = 4;

  typedef enum logic [1:0] {
    WL8  = 2'd0,
    WL10 = 2'd1,
    WL12 = 2'd2,
    WL16 = 2'd3
  } wordLen_e;

  typedef struct packed {
    logic restart;
    logic wordTick;
    logic fsInt;
  } bfcStrb_t;

  function automatic logic [BIT_IDX_W-1:0] wordLastOf(input logic [1:0] sel);
    case (wordLen_e'(sel))
      WL8:     return BIT_IDX_W'(7);
      WL10:    return BIT_IDX_W'(9);
      WL12:    return BIT_IDX_W'(11);
      default: return BIT_IDX_W'(15);
    endcase
  endfunction

endpackage

// File: rtl/bfc_sync.sv
module bfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bfc_ctrl.sv
module bfc_ctrl
  import bfc_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int FRAME_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIV_W-1:0]   divVal,
  input  logic [1:0]         wordSel,
  input  logic [FRAME_W-1:0] frameLen,
  input  logic               bitSrcExt,
  input  logic               bitLevel,
  output bfcStrb_t           strb
);
  localparam int CFG_W = DIV_W + 2 + FRAME_W + 1;

  logic [CFG_W-1:0]     cfgNow, cfgQ;
  logic                 armQ;
  logic                 restart;
  logic                 bclkPrev;
  logic                 bitRise;
  logic [BIT_IDX_W-1:0] bitIdx, wordLast;
  logic [FRAME_W-1:0]   wordIdx;
  logic                 wordTickQ, fsQ;

  assign cfgNow   = {divVal, wordSel, frameLen, bitSrcExt};
  assign restart  = !armQ || (cfgNow != cfgQ);
  assign bitRise  = bitLevel && !bclkPrev;
  assign wordLast = wordLastOf(wordSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= '0;
      armQ      <= 1'b0;
      bclkPrev  <= 1'b0;
      bitIdx    <= '0;
      wordIdx   <= '0;
      wordTickQ <= 1'b0;
      fsQ       <= 1'b0;
    end else begin
      cfgQ     <= cfgNow;
      armQ     <= 1'b1;
      bclkPrev <= bitLevel;
      if (restart) begin
        bitIdx    <= wordLast;
        wordIdx   <= frameLen;
        wordTickQ <= 1'b0;
        fsQ       <= 1'b0;
      end else if (bitRise) begin
        if (bitIdx == wordLast) begin
          bitIdx    <= '0;
          wordTickQ <= 1'b1;
          if (wordIdx == frameLen) begin
            wordIdx <= '0;
            fsQ     <= 1'b1;
          end else begin
            wordIdx <= wordIdx + FRAME_W'(1);
            fsQ     <= 1'b0;
          end
        end else begin
          bitIdx    <= bitIdx + BIT_IDX_W'(1);
          wordTickQ <= 1'b0;
          fsQ       <= 1'b0;
        end
      end else begin
        wordTickQ <= 1'b0;
      end
    end
  end

  assign strb.restart  = restart;
  assign strb.wordTick = wordTickQ;
  assign strb.fsInt    = fsQ;
endmodule

// File: rtl/bfc_dpath.sv
module bfc_dpath
  import bfc_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic [DIV_W-1:0] divVal,
  input  logic             bitSrcExt,
  input  logic             fsSrcExt,
  input  logic             bitClkInv,
  input  logic             fsInv,
  input  logic             extBitClk,
  input  logic             extFrameSync,
  input  bfcStrb_t         strb,
  output logic             bitLevel,
  output logic             bitClkOut,
  output logic             frameSyncOut
);
  logic [DIV_W-1:0] preCnt;
  logic             bclkInt;
  logic             extBclkS, extFsS;
  logic             fsSel;

  bfc_sync #(.STAGES(SYNC_STAGES)) u_syncBclk (
    .clk(clk), .rstN(rstN), .din(extBitClk), .dout(extBclkS)
  );
  bfc_sync #(.STAGES(SYNC_STAGES)) u_syncFs (
    .clk(clk), .rstN(rstN), .din(extFrameSync), .dout(extFsS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      bclkInt <= 1'b0;
    end else if (strb.restart) begin
      preCnt  <= '0;
      bclkInt <= 1'b0;
    end else if (clkEn) begin
      if (preCnt == divVal) begin
        preCnt  <= '0;
        bclkInt <= !bclkInt;
      end else begin
        preCnt <= preCnt + DIV_W'(1);
      end
    end
  end

  assign bitLevel = bitSrcExt ? extBclkS : bclkInt;
  assign fsSel    = fsSrcExt ? extFsS : strb.fsInt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClkOut    <= 1'b0;
      frameSyncOut <= 1'b0;
    end else begin
      bitClkOut    <= bitLevel ^ bitClkInv;
      frameSyncOut <= fsSel ^ fsInv;
    end
  end
endmodule

// File: rtl/bit_frame_clkgen.sv
module bit_frame_clkgen
  import bfc_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int FRAME_W     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clkEn,
  input  logic [DIV_W-1:0]   divVal,
  input  logic [1:0]         wordSel,
  input  logic [FRAME_W-1:0] frameLen,
  input  logic               bitSrcExt,
  input  logic               fsSrcExt,
  input  logic               bitClkInv,
  input  logic               fsInv,
  input  logic               extBitClk,
  input  logic               extFrameSync,
  output logic               bitClkOut,
  output logic               wordTick,
  output logic               frameSyncOut
);
  bfcStrb_t strb;
  logic     bitLevel;

  bfc_ctrl #(.DIV_W(DIV_W), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .divVal(divVal), .wordSel(wordSel),
    .frameLen(frameLen), .bitSrcExt(bitSrcExt), .bitLevel(bitLevel),
    .strb(strb)
  );

  bfc_dpath #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .divVal(divVal),
    .bitSrcExt(bitSrcExt), .fsSrcExt(fsSrcExt), .bitClkInv(bitClkInv),
    .fsInv(fsInv), .extBitClk(extBitClk), .extFrameSync(extFrameSync),
    .strb(strb), .bitLevel(bitLevel), .bitClkOut(bitClkOut),
    .frameSyncOut(frameSyncOut)
  );

  assign wordTick = strb.wordTick;
endmodule

// File: rtl/bfc_chk.sv
module bfc_chk
  import bfc_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     clkEn,
  input logic     bitSrcExt,
  input logic     bitLevel,
  input bfcStrb_t strb
);
  // R2
  frozen_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !bitSrcExt && !strb.restart) |=> (bitSrcExt || $stable(bitLevel)));

  // R3
  word_tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordTick |=> !strb.wordTick);

  // R5
  fs_at_word_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.fsInt) |-> strb.wordTick);

  // R10
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (!strb.fsInt && !strb.wordTick));
endmodule

bind bit_frame_clkgen bfc_chk u_chk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .bitSrcExt(bitSrcExt),
  .bitLevel(bitLevel), .strb(strb)
);

// File: tb/bit_frame_clkgen_tb.sv
`timescale 1ns/1ps
module bit_frame_clkgen_tb;
  localparam int DIV_W   = 8;
  localparam int FRAME_W = 5;
  localparam int NVEC    = 6;
  // columns: divide, word code, frame code, external bit source, half period, frame cycles
  localparam int VEC [NVEC][6] = '{
    '{0, 0,  0, 0, 1,   16},
    '{1, 1,  2, 0, 2,  120},
    '{2, 2,  3, 0, 3,  288},
    '{0, 3, 31, 0, 1, 1024},
    '{3, 0,  1, 0, 4,  128},
    '{0, 0,  1, 1, 5,  160}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b1;
  logic [DIV_W-1:0] divVal = '0;
  logic [1:0] wordSel = '0;
  logic [FRAME_W-1:0] frameLen = '0;
  logic bitSrcExt = 1'b0, fsSrcExt = 1'b0, bitClkInv = 1'b0, fsInv = 1'b0;
  logic extBitClk = 1'b0, extFrameSync = 1'b0;
  logic bitClkOut, wordTick, frameSyncOut;

  int checks = 0;
  int errors = 0;
  int extCnt = 0;

  always #2 clk = ~clk;

  bit_frame_clkgen #(.DIV_W(DIV_W), .FRAME_W(FRAME_W)) u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .divVal(divVal), .wordSel(wordSel),
    .frameLen(frameLen), .bitSrcExt(bitSrcExt), .fsSrcExt(fsSrcExt),
    .bitClkInv(bitClkInv), .fsInv(fsInv), .extBitClk(extBitClk),
    .extFrameSync(extFrameSync), .bitClkOut(bitClkOut), .wordTick(wordTick),
    .frameSyncOut(frameSyncOut)
  );

  // external bit clock: half period of five cycles
  always @(negedge clk) begin
    if (extCnt == 4) begin
      extCnt <= 0;
      extBitClk <= ~extBitClk;
    end else begin
      extCnt <= extCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic runVec(input int i);
    logic prevFs, prevB;
    int cyc, fsHigh, ticks, bHigh, bRise, guard;
    string bitReq;
    bitReq = (VEC[i][3] != 0) ? "R8" : "R1";
    @(negedge clk);
    divVal    = DIV_W'(VEC[i][0]);
    wordSel   = 2'(VEC[i][1]);
    frameLen  = FRAME_W'(VEC[i][2]);
    bitSrcExt = (VEC[i][3] != 0);
    prevFs = frameSyncOut;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (frameSyncOut && !prevFs) break;
      prevFs = frameSyncOut;
      if (guard > 5000) break;
    end
    prevFs = 1'b1;
    prevB  = bitClkOut;
    cyc = 0; fsHigh = 0; ticks = 0; bHigh = 0; bRise = 0;
    fsHigh += 1;
    ticks  += int'(wordTick);
    bHigh  += int'(bitClkOut);
    cyc = 1;
    forever begin
      @(negedge clk);
      if (frameSyncOut && !prevFs) break;
      prevFs = frameSyncOut;
      cyc++;
      fsHigh += int'(frameSyncOut);
      ticks  += int'(wordTick);
      bHigh  += int'(bitClkOut);
      if (bitClkOut && !prevB) bRise++;
      prevB = bitClkOut;
      if (cyc > 5000) break;
    end
    if (bitClkOut && !prevB) bRise++;
    check(cyc == VEC[i][5], "R4 frame spacing", cyc, VEC[i][5]);
    check(fsHigh == 2 * VEC[i][4], "R5 sync width", fsHigh, 2 * VEC[i][4]);
    check(ticks == VEC[i][2] + 1, "R3 ticks per frame", ticks, VEC[i][2] + 1);
    check(bRise == VEC[i][5] / (2 * VEC[i][4]), {bitReq, " bit edges"}, bRise,
          VEC[i][5] / (2 * VEC[i][4]));
    check(bHigh == bRise * VEC[i][4], {bitReq, " high time"}, bHigh, bRise * VEC[i][4]);
  endtask

  initial begin
    logic vB, vF;
    bit stableOk;
    // R11 reset state
    repeat (3) @(negedge clk);
    check(bitClkOut == 1'b0, "R11 bit clock in reset", int'(bitClkOut), 0);
    check(wordTick == 1'b0, "R11 word tick in reset", int'(wordTick), 0);
    check(frameSyncOut == 1'b0, "R11 sync in reset", int'(frameSyncOut), 0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) runVec(i);

    // back to internal source, N=1
    runVec(1);

    // R2 freeze
    @(negedge clk);
    clkEn = 1'b0;
    repeat (4) @(negedge clk);
    vB = bitClkOut;
    vF = frameSyncOut;
    stableOk = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (bitClkOut != vB || frameSyncOut != vF) stableOk = 1'b0;
    end
    check(stableOk, "R2 frozen bit clock", int'(bitClkOut), int'(vB));

    // R6 bit clock inversion
    bitClkInv = 1'b1;
    repeat (3) @(negedge clk);
    check(bitClkOut == ~vB, "R6 inverted bit clock", int'(bitClkOut), int'(~vB));
    bitClkInv = 1'b0;
    repeat (3) @(negedge clk);
    check(bitClkOut == vB, "R6 restored bit clock", int'(bitClkOut), int'(vB));

    // R7 frame sync inversion
    fsInv = 1'b1;
    repeat (3) @(negedge clk);
    check(frameSyncOut == ~vF, "R7 inverted sync", int'(frameSyncOut), int'(~vF));
    fsInv = 1'b0;
    repeat (3) @(negedge clk);
    check(frameSyncOut == vF, "R7 restored sync", int'(frameSyncOut), int'(vF));

    // R9 external frame sync
    fsSrcExt = 1'b1;
    extFrameSync = 1'b1;
    repeat (4) @(negedge clk);
    check(frameSyncOut == 1'b1, "R9 external sync high", int'(frameSyncOut), 1);
    extFrameSync = 1'b0;
    repeat (4) @(negedge clk);
    check(frameSyncOut == 1'b0, "R9 external sync low", int'(frameSyncOut), 0);
    fsInv = 1'b1;
    repeat (4) @(negedge clk);
    check(frameSyncOut == 1'b1, "R9 external sync inverted", int'(frameSyncOut), 1);
    fsInv = 1'b0;
    fsSrcExt = 1'b0;
    clkEn = 1'b1;
    repeat (40) @(negedge clk);

    // R10 restart timing, N=1: low after 3 edges, high after 4
    frameLen = FRAME_W'(5);
    @(posedge clk);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(frameSyncOut == 1'b0, "R10 no early sync", int'(frameSyncOut), 0);
    @(posedge clk);
    @(negedge clk);
    check(frameSyncOut == 1'b1, "R10 first sync", int'(frameSyncOut), 1);

    finishRun();
  end
endmodule